// File: doc/BRIEF.md
# Multi-Channel SPI Register Access Frontend

This block sits between an SPI bus and the register file of a four-channel UART. The SPI interface runs in mode 0: the clock idles low, and data is sampled on the rising edge, most significant bit first. The pins are oversampled by the system clock through a synchronizer. Each transaction opens with a command byte that chooses read or write, one of the channels and a register address. The bytes that follow are data. While chip select stays low, each further data byte repeats the access at the same address. A burst of writes to the transmit register therefore fills that channel's transmit FIFO. A burst of reads from the receive register steps through the receive FIFO, because the register file pops one entry on each read strobe.

The frontend gives the register file a simple access port: channel, address, write data, a one-cycle write strobe and a one-cycle read strobe. Read data comes back combinationally one cycle after the address is stable. The read strobe marks a completed read and triggers any side effects of the read, such as popping a FIFO or clearing a status register. The frontend issues it only after the master has clocked all eight bits of a data byte.

One address is reserved for a global command register, and all accesses to it go to channel 0. Two magic values written there switch a secondary register page on and off. While that page is on, a fixed address returns a revision constant instead of register-file data.

Top module: `spi_mp_frontend`

## Requirements
- R1: Command byte: bit 7 set means write and clear means read; bits 6:5 select the channel; bits 4:0 select the address. Bits shift in most significant first and are sampled on rising SCLK while CS_n is low.
- R2: In a write transaction, each completed data byte produces exactly one one-cycle wr_stb_o, with the decoded channel, the decoded address and the byte on wdata_o.
- R3: Within one transaction, writes to the transmit address (0x00) are capped at FIFO_DEPTH (128) strobes. Further bytes in that transaction are dropped.
- R4: In a read transaction, each data byte shifts out on miso_o, most significant bit first, with bits changing on falling SCLK. The byte is the rd_data_i value presented before the byte starts. One one-cycle rd_stb_o follows each completed data byte.
- R5: The address never auto-increments within a burst. Successive read bytes re-read the same address, so the receive address (0x00) yields successive FIFO entries and any other address yields its current value each time.
- R6: Any strobe to the global address 0x1F carries channel 0, whatever channel bits the command held.
- R7: Writing 0xCE to 0x1F turns the secondary page on, and writing 0xCD turns it off. Any other value leaves the page state unchanged. Writes to 0x1F never produce wr_stb_o.
- R8: While the secondary page is on, reads of address 0x05 return REV_ID (default 0xB2) and produce no rd_stb_o. While it is off, 0x05 is an ordinary register.
- R9: Raising CS_n before a byte is complete discards that byte and produces no strobe. The next transaction starts with a fresh command byte.
- R10: After reset, or while CS_n is high, both strobes are low and miso_o is 0. The secondary page is off after reset.
- R11: wr_stb_o and rd_stb_o are never high in the same cycle, and neither is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | SPI serial clock, asynchronous |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | SPI data from master |
| miso_o | output | 1 | SPI data to master |
| chan_o | output | 2 | Channel of the current access |
| addr_o | output | 5 | Register address of the current access |
| wdata_o | output | 8 | Write data |
| wr_stb_o | output | 1 | One-cycle write strobe |
| rd_stb_o | output | 1 | One-cycle read strobe, marks read side effects |
| rd_data_i | input | 8 | Register-file read data for chan_o/addr_o |

## Verification
The assertions assume that the master keeps each SCLK phase at least eight system clocks long. They also assume that CS_n changes only while SCLK is low and at least one half period away from any SCLK edge. Under those conditions no byte completes during the synchronizer lag after CS_n rises, so no strobe can appear more than four cycles after chip select goes high. The bench drives SCLK with fixed eight-clock phases and moves CS_n only a half period away from SCLK edges. This keeps every transaction, including the aborted ones, inside those conditions.

// File: rtl/spi_mp_pkg.sv
package spi_mp_pkg;
  typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD} phase_e;
  typedef enum logic [1:0] {LD_IDLE, LD_WAIT, LD_GO} load_e;
endpackage

// File: rtl/spi_mp_sync.sv
module spi_mp_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= RST_VAL;
      else if (g == 0) stage_q[g] <= d_i;
      else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_mp_shift.sv
module spi_mp_shift #(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          cs_ni,
  input  logic          mosi_i,
  input  logic          load_i,
  input  logic [BW-1:0] load_byte_i,
  output logic          done_o,
  output logic [BW-1:0] byte_o,
  output logic          miso_o
);
  localparam int CW = $clog2(BW);

  logic          sclk_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] rx_q, tx_q;
  logic          rise, fall;
  logic          last_bit;
  logic [BW-1:0] rx_next;

  assign rise     = sclk_i & ~sclk_q;
  assign fall     = ~sclk_i & sclk_q;
  assign last_bit = (cnt_q == CW'(BW-1));
  assign rx_next  = {rx_q[BW-2:0], mosi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      done_o <= 1'b0;
      byte_o <= '0;
    end else begin
      sclk_q <= sclk_i;
      done_o <= 1'b0;
      if (cs_ni) begin
        // partial byte dropped here
        cnt_q <= '0;
        rx_q  <= '0;
        tx_q  <= '0;
      end else begin
        if (rise) begin
          rx_q  <= rx_next;
          cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
          if (last_bit) begin
            done_o <= 1'b1;
            byte_o <= rx_next;
          end
        end
        // no shift on the fall that closes a byte: next byte's MSB is preloaded
        if (load_i) tx_q <= load_byte_i;
        else if (fall && cnt_q != '0) tx_q <= {tx_q[BW-2:0], 1'b0};
      end
    end
  end

  assign miso_o = tx_q[BW-1];
endmodule

// File: rtl/spi_mp_ctrl.sv
module spi_mp_ctrl
  import spi_mp_pkg::*;
#(
  parameter int                       CH_W       = 2,
  parameter int                       ADDR_W     = 5,
  parameter int                       FIFO_DEPTH = 128,
  parameter logic [ADDR_W-1:0]        THR_ADDR   = '0,
  parameter logic [ADDR_W-1:0]        GLB_ADDR   = '1,
  parameter logic [ADDR_W-1:0]        REV_ADDR   = ADDR_W'(5),
  parameter logic [CH_W+ADDR_W:0]     REV_ID     = 8'hB2,
  parameter logic [CH_W+ADDR_W:0]     EXT_ON     = 8'hCE,
  parameter logic [CH_W+ADDR_W:0]     EXT_OFF    = 8'hCD
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cs_ni,
  input  logic                    done_i,
  input  logic [CH_W+ADDR_W:0]    byte_i,
  input  logic [CH_W+ADDR_W:0]    rd_data_i,
  output logic [CH_W-1:0]         chan_o,
  output logic [ADDR_W-1:0]       addr_o,
  output logic [CH_W+ADDR_W:0]    wdata_o,
  output logic                    wr_stb_o,
  output logic                    rd_stb_o,
  output logic                    load_o,
  output logic [CH_W+ADDR_W:0]    load_byte_o
);
  localparam int BW    = 1 + CH_W + ADDR_W;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  phase_e             phase_q;
  load_e              ld_q;
  logic               ext_q;
  logic [CNT_W-1:0]   burst_q;
  logic               rev_hit;
  logic               thr_full;
  logic [ADDR_W-1:0]  cmd_addr;

  assign cmd_addr = byte_i[ADDR_W-1:0];
  assign rev_hit  = ext_q && (addr_o == REV_ADDR);
  assign thr_full = (addr_o == THR_ADDR) && (burst_q == CNT_W'(FIFO_DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_CMD;
      ld_q     <= LD_IDLE;
      ext_q    <= 1'b0;
      burst_q  <= '0;
      chan_o   <= '0;
      addr_o   <= '0;
      wdata_o  <= '0;
      wr_stb_o <= 1'b0;
      rd_stb_o <= 1'b0;
    end else begin
      wr_stb_o <= 1'b0;
      rd_stb_o <= 1'b0;
      unique case (ld_q)
        LD_WAIT: ld_q <= LD_GO;
        LD_GO:   ld_q <= LD_IDLE;
        default: ld_q <= LD_IDLE;
      endcase
      if (cs_ni) begin
        phase_q <= PH_CMD;
        ld_q    <= LD_IDLE;
      end else if (done_i) begin
        unique case (phase_q)
          PH_CMD: begin
            addr_o  <= cmd_addr;
            chan_o  <= (cmd_addr == GLB_ADDR) ? '0 : byte_i[ADDR_W +: CH_W];
            burst_q <= '0;
            if (byte_i[BW-1]) begin
              phase_q <= PH_WR;
            end else begin
              phase_q <= PH_RD;
              ld_q    <= LD_WAIT;
            end
          end
          PH_WR: begin
            if (addr_o == GLB_ADDR) begin
              if (byte_i == EXT_ON) ext_q <= 1'b1;
              else if (byte_i == EXT_OFF) ext_q <= 1'b0;
            end else if (!thr_full) begin
              wr_stb_o <= 1'b1;
              wdata_o  <= byte_i;
              if (addr_o == THR_ADDR) burst_q <= burst_q + 1'b1;
            end
          end
          PH_RD: begin
            if (!rev_hit) rd_stb_o <= 1'b1;
            ld_q <= LD_WAIT;
          end
          default: phase_q <= PH_CMD;
        endcase
      end
    end
  end

  // load two cycles after a byte boundary: address settled, pop visible
  assign load_o      = (ld_q == LD_GO);
  assign load_byte_o = rev_hit ? REV_ID : rd_data_i;
endmodule

// File: rtl/spi_mp_frontend.sv
module spi_mp_frontend #(
  parameter int                    CH_W        = 2,
  parameter int                    ADDR_W      = 5,
  parameter int                    FIFO_DEPTH  = 128,
  parameter int                    SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0]     THR_ADDR    = '0,
  parameter logic [ADDR_W-1:0]     GLB_ADDR    = '1,
  parameter logic [ADDR_W-1:0]     REV_ADDR    = ADDR_W'(5),
  parameter logic [CH_W+ADDR_W:0]  REV_ID      = 8'hB2,
  parameter logic [CH_W+ADDR_W:0]  EXT_ON      = 8'hCE,
  parameter logic [CH_W+ADDR_W:0]  EXT_OFF     = 8'hCD
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sclk_i,
  input  logic                   cs_ni,
  input  logic                   mosi_i,
  output logic                   miso_o,
  output logic [CH_W-1:0]        chan_o,
  output logic [ADDR_W-1:0]      addr_o,
  output logic [CH_W+ADDR_W:0]   wdata_o,
  output logic                   wr_stb_o,
  output logic                   rd_stb_o,
  input  logic [CH_W+ADDR_W:0]   rd_data_i
);
  localparam int BW = 1 + CH_W + ADDR_W;

  logic [2:0]    pins_s;
  logic          sclk_s, cs_n_s, mosi_s;
  logic          done;
  logic [BW-1:0] rx_byte;
  logic          load;
  logic [BW-1:0] load_byte;

  spi_mp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sclk_i, cs_ni, mosi_i}),
    .q_o    (pins_s)
  );
  assign {sclk_s, cs_n_s, mosi_s} = pins_s;

  spi_mp_shift #(.BW(BW)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (sclk_s),
    .cs_ni       (cs_n_s),
    .mosi_i      (mosi_s),
    .load_i      (load),
    .load_byte_i (load_byte),
    .done_o      (done),
    .byte_o      (rx_byte),
    .miso_o      (miso_o)
  );

  spi_mp_ctrl #(
    .CH_W(CH_W), .ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH),
    .THR_ADDR(THR_ADDR), .GLB_ADDR(GLB_ADDR), .REV_ADDR(REV_ADDR),
    .REV_ID(REV_ID), .EXT_ON(EXT_ON), .EXT_OFF(EXT_OFF)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_ni       (cs_n_s),
    .done_i      (done),
    .byte_i      (rx_byte),
    .rd_data_i   (rd_data_i),
    .chan_o      (chan_o),
    .addr_o      (addr_o),
    .wdata_o     (wdata_o),
    .wr_stb_o    (wr_stb_o),
    .rd_stb_o    (rd_stb_o),
    .load_o      (load),
    .load_byte_o (load_byte)
  );
endmodule

// File: rtl/spi_mp_frontend_chk.sv
module spi_mp_frontend_chk #(
  parameter int                CH_W     = 2,
  parameter int                ADDR_W   = 5,
  parameter logic [ADDR_W-1:0] GLB_ADDR = '1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              miso_o,
  input logic [CH_W-1:0]   chan_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              wr_stb_o,
  input logic              rd_stb_o
);
  logic [2:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_cnt_q <= '0;
    else if (!cs_ni) hi_cnt_q <= '0;
    else if (hi_cnt_q != 3'd7) hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  p_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_stb_o && rd_stb_o));

  p_wr_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o);

  p_rd_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stb_o |=> !rd_stb_o);

  p_glb_chan_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_stb_o || rd_stb_o) && addr_o == GLB_ADDR) |-> chan_o == '0);

  p_glb_nowr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> addr_o != GLB_ADDR);

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_cnt_q >= 3'd4) |-> (!wr_stb_o && !rd_stb_o));

  p_idle_miso_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_cnt_q >= 3'd4) |-> !miso_o);
endmodule

bind spi_mp_frontend spi_mp_frontend_chk #(
  .CH_W(CH_W), .ADDR_W(ADDR_W), .GLB_ADDR(GLB_ADDR)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .miso_o   (miso_o),
  .chan_o   (chan_o),
  .addr_o   (addr_o),
  .wr_stb_o (wr_stb_o),
  .rd_stb_o (rd_stb_o)
);

// File: tb/spi_mp_frontend_bench.sv
`timescale 1ns/1ps
module spi_mp_frontend_bench;
  localparam int HALF = 8;
  localparam logic [7:0] REV = 8'hB2;
  localparam int ISR = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [1:0] chan;
  logic [4:0] addr;
  logic [7:0] wdata, rd_data;
  logic wr_stb, rd_stb;

  int n_chk = 0, n_bad = 0, n_wr = 0, n_rd = 0;
  bit finished = 0;

  logic [7:0] regs [4][32];
  logic [7:0] rxq [$];
  logic [7:0] txq [$];
  logic [1:0] txc [$];
  logic [7:0] rbuf [$];
  int rx_ch = 0;

  always #2 clk = ~clk;

  spi_mp_frontend u_spi_mp_frontend (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .chan_o(chan), .addr_o(addr), .wdata_o(wdata),
    .wr_stb_o(wr_stb), .rd_stb_o(rd_stb), .rd_data_i(rd_data)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FIL%s %s actual=%0h expected=%0h", "", req, act, exp);
    end
  endtask

  // behavioural register file, updated away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_stb && wr_stb) check("R11 both strobes", 1, 0);
      if ((rd_stb || wr_stb) && addr == 5'h1F) check("R6 global chan", int'(chan), 0);
      if (rd_stb) begin
        n_rd++;
        if (addr == 5'd0) begin
          if (int'(chan) == rx_ch && rxq.size() > 0) void'(rxq.pop_front());
        end else if (addr == 5'(ISR)) regs[chan][ISR] = 8'h00;
      end
      if (wr_stb) begin
        n_wr++;
        if (addr == 5'd0) begin
          txq.push_back(wdata);
          txc.push_back(chan);
        end else regs[chan][addr] = wdata;
      end
    end
    if (addr == 5'd0) rd_data = (int'(chan) == rx_ch && rxq.size() > 0) ? rxq[0] : 8'h00;
    else rd_data = regs[chan][addr];
  end

  task automatic send_bits(input logic [7:0] t, input int n, output logic [7:0] r);
    r = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = t[i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      r[i] = miso;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic wr_burst(input int ch, input int a, input int n, input logic [7:0] base);
    logic [7:0] r;
    cs_lo();
    send_bits({1'b1, 2'(ch), 5'(a)}, 8, r);
    for (int i = 0; i < n; i++) send_bits(base + 8'(i), 8, r);
    cs_hi();
  endtask

  task automatic rd_burst(input int ch, input int a, input int n);
    logic [7:0] r;
    rbuf.delete();
    cs_lo();
    send_bits({1'b0, 2'(ch), 5'(a)}, 8, r);
    for (int i = 0; i < n; i++) begin
      send_bits(8'h00, 8, r);
      rbuf.push_back(r);
    end
    cs_hi();
  endtask

  initial begin
    int w0, r0;
    logic [7:0] dmy;
    for (int c = 0; c < 4; c++)
      for (int a = 0; a < 32; a++) regs[c][a] = 8'h00;
    repeat (5) @(negedge clk);
    check("R10 reset wr_stb", int'(wr_stb), 0);
    check("R10 reset rd_stb", int'(rd_stb), 0);
    check("R10 reset miso", int'(miso), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 R2 R4: write then read back, channel decode
    w0 = n_wr;
    wr_burst(2, 3, 1, 8'h5A);
    check("R2 one write strobe", n_wr - w0, 1);
    check("R2 write data ch2", int'(regs[2][3]), 'h5A);
    wr_burst(1, 3, 1, 8'h11);
    check("R1 channel isolation", int'(regs[2][3]), 'h5A);
    rd_burst(2, 3, 1);
    check("R4 read ch2", int'(rbuf[0]), 'h5A);
    rd_burst(1, 3, 1);
    check("R1 read ch1", int'(rbuf[0]), 'h11);
    check("R10 miso idle", int'(miso), 0);

    // R2 transmit burst
    txq.delete(); txc.delete();
    wr_burst(3, 0, 5, 8'h40);
    check("R2 burst count", txq.size(), 5);
    for (int k = 0; k < 5; k++) begin
      check("R2 burst data", int'(txq[k]), 'h40 + k);
      check("R2 burst chan", int'(txc[k]), 3);
    end

    // R3 cap at FIFO depth
    txq.delete(); txc.delete();
    wr_burst(0, 0, 130, 8'h00);
    check("R3 capped count", txq.size(), 128);
    check("R3 last kept", int'(txq[127]), 127);

    // R5 receive FIFO stepping
    rx_ch = 1;
    rxq.push_back(8'hA1); rxq.push_back(8'hA2); rxq.push_back(8'hA3);
    rd_burst(1, 0, 3);
    check("R5 rx 0", int'(rbuf[0]), 'hA1);
    check("R5 rx 1", int'(rbuf[1]), 'hA2);
    check("R5 rx 2", int'(rbuf[2]), 'hA3);
    check("R5 rx drained", rxq.size(), 0);

    // R5 no auto-increment
    regs[2][4] = 8'h3C; regs[2][5] = 8'hEE;
    r0 = n_rd;
    rd_burst(2, 4, 2);
    check("R5 repeat 0", int'(rbuf[0]), 'h3C);
    check("R5 repeat 1", int'(rbuf[1]), 'h3C);
    check("R4 strobe per byte", n_rd - r0, 2);

    // R4 read-to-clear, one strobe
    regs[1][ISR] = 8'h80;
    r0 = n_rd;
    rd_burst(1, ISR, 1);
    check("R4 isr value", int'(rbuf[0]), 'h80);
    check("R4 isr one strobe", n_rd - r0, 1);
    rd_burst(1, ISR, 1);
    check("R4 isr cleared", int'(rbuf[0]), 0);

    // R7 R8 secondary page
    regs[0][5] = 8'h33;
    rd_burst(0, 5, 1);
    check("R8 page off", int'(rbuf[0]), 'h33);
    w0 = n_wr;
    wr_burst(2, 31, 1, 8'hCE);
    check("R7 no strobe on 1F", n_wr - w0, 0);
    r0 = n_rd;
    rd_burst(0, 5, 1);
    check("R8 revision", int'(rbuf[0]), int'(REV));
    check("R8 no rd strobe", n_rd - r0, 0);
    wr_burst(0, 31, 1, 8'h12);
    rd_burst(0, 5, 1);
    check("R7 other value ignored", int'(rbuf[0]), int'(REV));
    wr_burst(0, 31, 1, 8'hCD);
    rd_burst(0, 5, 1);
    check("R7 page off again", int'(rbuf[0]), 'h33);

    // R6 global via channel 0
    regs[0][31] = 8'h77; regs[3][31] = 8'h99;
    rd_burst(3, 31, 1);
    check("R6 global read", int'(rbuf[0]), 'h77);

    // R9 aborts
    w0 = n_wr;
    cs_lo();
    send_bits({1'b1, 2'd0, 5'd6}, 4, dmy);
    cs_hi();
    check("R9 cmd abort", n_wr - w0, 0);
    wr_burst(0, 6, 1, 8'h44);
    check("R9 fresh command", int'(regs[0][6]), 'h44);
    w0 = n_wr;
    cs_lo();
    send_bits({1'b1, 2'd0, 5'd6}, 8, dmy);
    send_bits(8'hFF, 3, dmy);
    cs_hi();
    check("R9 data abort strobes", n_wr - w0, 0);
    check("R9 data abort value", int'(regs[0][6]), 'h44);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule